// File: doc/BRIEF.md
# Three-Phase Energy Accumulator Bank

This block keeps a running energy total for each of three phases. On every sample strobe, each phase presents a signed power value. A per-phase integrator adds that value to a wide running sum. When the sum reaches a programmable threshold, the integrator emits a +1 energy quantum. When the sum falls to minus the threshold, it emits a −1 quantum. Each quantum moves a 32-bit signed accumulator by one count, and the accumulator wraps freely across the signed range in both directions.

A half-full event is raised whenever a quantum step changes bit 30 of any accumulator. The event sets a sticky status flag. Through a mask bit, that flag drives an active-low interrupt line. The host sees a small register port. Reads complete one cycle later through a two-state sequencer (`HOST_IDLE` → `HOST_RESP` on a read, `HOST_RESP` → `HOST_RESP` on a back-to-back read, and `HOST_RESP` → `HOST_IDLE` otherwise). Writes clear the status by writing one, preload accumulators, and set the mask, the mode and the threshold. An optional mode clears an accumulator each time the host reads it.

The register map is as follows:
- Address 0, 1 and 2 hold the accumulators for phases A, B and C.
- Address 3 is the status register; the flag is bit 4.
- Address 4 is the mask register; bit 4 enables the interrupt.
- Address 5 is the mode register; bit 0 enables clear-on-read.
- Address 6 is the threshold.

Top module: `energy_acc_bank`

## Requirements
- R1: Each accumulator is 32-bit two's complement. A +1 quantum taken at 0x7FFFFFFF yields 0x80000000.
- R2: A −1 quantum taken at 0x80000000 yields 0x7FFFFFFF.
- R3: On a strobe sampled at edge e, the phase integrator forms the sum of its running value and the power sample. If the sum is at least the threshold, the integrator subtracts the threshold and emits +1. If the sum is at most minus the threshold, it adds the threshold and emits −1. Otherwise it keeps the sum. The accumulator shows the quantum after edge e+1.
- R4: Status bit 4 (address 3) becomes 1 at the edge where a quantum step changes bit 30 of any accumulator. Loads and clear-on-read never raise it.
- R5: irq_n is 0 exactly while status bit 4 and mask bit 4 (address 4) are both 1. Otherwise irq_n is 1.
- R6: A write to address 3 with data bit 4 = 1 clears the status flag. With bit 4 = 0 the flag is unchanged. If a half-full event occurs in the same cycle as the clear, the flag stays set.
- R7: With mode bit 0 (address 5) set, a read of an accumulator returns its value from before that edge and leaves it at zero plus any quantum landing at the same edge. With the bit clear, reads leave the accumulators unchanged.
- R8: A read asserted at edge e gives host_rvalid = 1 and host_rdata after edge e. Reads of addresses 0–6 return the stored values; status reads return the flag in bit 4. Address 7 reads as 0.
- R9: A write to address 0, 1 or 2 loads that accumulator. A quantum landing at the same edge is added on top of the loaded value.
- R10: After reset all accumulators, integrators, status, mask and mode are 0, the threshold is THR_RST (default 1), and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle power sample strobe, shared by all phases |
| pwr_a | input | PWR_W | Signed power sample, phase A |
| pwr_b | input | PWR_W | Signed power sample, phase B |
| pwr_c | input | PWR_W | Signed power sample, phase C |
| host_wr | input | 1 | Register write enable |
| host_rd | input | 1 | Register read enable |
| host_addr | input | 3 | Register address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | High for the cycle after each read request |
| irq_n | output | 1 | Active-low half-full interrupt |

## Verification
Read data and host_rvalid are due one edge after the read request. The status flag and irq_n respond at the same edge as the quantum step that causes them. A strobe reaches the accumulator two edges after it is sampled: one edge for the integrator and one for the accumulator. The bench drives all inputs on the falling edge. A behavioural model advances on each rising edge and is compared with the outputs at every falling edge, so every result is checked in the cycle it becomes due. The coincidence cases are built from exact cycle offsets: a strobe is issued, and on the next cycle a status clear, a clear-on-read or a load lands on the edge where the quantum commits.

// File: rtl/energy_pkg.sv
package energy_pkg;
    localparam int NPH    = 3;
    localparam int ADDR_W = 3;
    localparam int REG_W  = 32;
    localparam int HF_BIT = 4;
    localparam int RDCLR_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        RA_ACC_A  = 3'd0,
        RA_ACC_B  = 3'd1,
        RA_ACC_C  = 3'd2,
        RA_STATUS = 3'd3,
        RA_MASK   = 3'd4,
        RA_MODE   = 3'd5,
        RA_THRESH = 3'd6
    } reg_addr_e;

    typedef enum logic {
        HOST_IDLE = 1'b0,
        HOST_RESP = 1'b1
    } host_state_e;
endpackage

// File: rtl/phase_integrator.sv
module phase_integrator #(
    parameter int PWR_W = 24,
    parameter int THR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb,
    input  logic signed [PWR_W-1:0] power,
    input  logic        [THR_W-1:0] thr,
    output logic                    q_up,
    output logic                    q_dn
);
    localparam int INT_W = ((THR_W > PWR_W) ? THR_W : PWR_W) + 2;

    logic signed [INT_W-1:0] integ_q;
    logic signed [INT_W-1:0] sum;
    logic signed [INT_W-1:0] thr_s;

    always_comb begin
        thr_s = $signed({{(INT_W-THR_W){1'b0}}, thr});
        sum   = integ_q + $signed({{(INT_W-PWR_W){power[PWR_W-1]}}, power});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q <= '0;
            q_up    <= 1'b0;
            q_dn    <= 1'b0;
        end else begin
            q_up <= 1'b0;
            q_dn <= 1'b0;
            if (stb) begin
                if (sum >= thr_s) begin
                    integ_q <= sum - thr_s;
                    q_up    <= 1'b1;
                end else if (sum <= -thr_s) begin
                    integ_q <= sum + thr_s;
                    q_dn    <= 1'b1;
                end else begin
                    integ_q <= sum;
                end
            end
        end
    end
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_up,
    input  logic             q_dn,
    input  logic             load,
    input  logic [ACC_W-1:0] load_val,
    input  logic             clr,
    output logic [ACC_W-1:0] acc,
    output logic             half_evt
);
    localparam int HALF_BIT = ACC_W - 2;

    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] nxt;

    always_comb begin
        if (load)     base = load_val;
        else if (clr) base = '0;
        else          base = acc;
        step     = {{(ACC_W-1){q_dn}}, q_up | q_dn};
        nxt      = base + step;
        half_evt = nxt[HALF_BIT] ^ base[HALF_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= nxt;
    end
endmodule

// File: rtl/host_regs.sv
module host_regs
    import energy_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int THR_W   = 32,
    parameter int THR_RST = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic                        rd,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [REG_W-1:0]            wdata,
    input  logic [NPH-1:0][ACC_W-1:0]   acc,
    input  logic [NPH-1:0]              half_evt,
    output logic [REG_W-1:0]            rdata,
    output logic                        rvalid,
    output logic                        irq_n,
    output logic [NPH-1:0]              load,
    output logic [NPH-1:0]              clr,
    output logic [THR_W-1:0]            thr,
    output logic                        hf_flag,
    output logic                        hf_en
);
    host_state_e      state_q, state_d;
    logic [7:0]       mask_q;
    logic [7:0]       mode_q;
    logic [REG_W-1:0] rd_mux;
    logic             any_evt;
    logic             w1c;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HOST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOST_IDLE: state_d = rd ? HOST_RESP : HOST_IDLE;
            HOST_RESP: state_d = rd ? HOST_RESP : HOST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rvalid = (state_q == HOST_RESP);
        hf_en  = mask_q[HF_BIT];
        irq_n  = ~(hf_flag & hf_en);
    end

    for (genvar p = 0; p < NPH; p++) begin : g_ctl
        assign load[p] = wr && (addr == ADDR_W'(p));
        assign clr[p]  = rd && (addr == ADDR_W'(p)) && mode_q[RDCLR_BIT];
    end

    always_comb begin
        any_evt = |half_evt;
        w1c     = wr && (addr == RA_STATUS) && wdata[HF_BIT];
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            RA_ACC_A:  rd_mux = REG_W'(acc[0]);
            RA_ACC_B:  rd_mux = REG_W'(acc[1]);
            RA_ACC_C:  rd_mux = REG_W'(acc[2]);
            RA_STATUS: rd_mux[HF_BIT] = hf_flag;
            RA_MASK:   rd_mux = REG_W'(mask_q);
            RA_MODE:   rd_mux = REG_W'(mode_q);
            RA_THRESH: rd_mux = REG_W'(thr);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hf_flag <= 1'b0;
            mask_q  <= '0;
            mode_q  <= '0;
            thr     <= THR_W'(THR_RST);
            rdata   <= '0;
        end else begin
            if (any_evt)  hf_flag <= 1'b1;
            else if (w1c) hf_flag <= 1'b0;
            if (wr && addr == RA_MASK)   mask_q <= wdata[7:0];
            if (wr && addr == RA_MODE)   mode_q <= wdata[7:0];
            if (wr && addr == RA_THRESH) thr    <= wdata[THR_W-1:0];
            if (rd) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/energy_acc_bank.sv
module energy_acc_bank
    import energy_pkg::*;
#(
    parameter int PWR_W   = 24,
    parameter int THR_W   = 32,
    parameter int ACC_W   = 32,
    parameter int THR_RST = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_stb,
    input  logic signed [PWR_W-1:0] pwr_a,
    input  logic signed [PWR_W-1:0] pwr_b,
    input  logic signed [PWR_W-1:0] pwr_c,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [2:0]              host_addr,
    input  logic [31:0]             host_wdata,
    output logic [31:0]             host_rdata,
    output logic                    host_rvalid,
    output logic                    irq_n
);
    logic signed [PWR_W-1:0]   pwr_vec [NPH];
    logic [NPH-1:0][ACC_W-1:0] acc_vec;
    logic [NPH-1:0]            q_up, q_dn, load, clr, half_evt;
    logic [THR_W-1:0]          thr;
    logic                      hf_flag, hf_en;

    assign pwr_vec[0] = pwr_a;
    assign pwr_vec[1] = pwr_b;
    assign pwr_vec[2] = pwr_c;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        phase_integrator #(.PWR_W(PWR_W), .THR_W(THR_W)) u_int (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (sample_stb),
            .power (pwr_vec[p]),
            .thr   (thr),
            .q_up  (q_up[p]),
            .q_dn  (q_dn[p])
        );
        phase_accum #(.ACC_W(ACC_W)) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .q_up     (q_up[p]),
            .q_dn     (q_dn[p]),
            .load     (load[p]),
            .load_val (host_wdata[ACC_W-1:0]),
            .clr      (clr[p]),
            .acc      (acc_vec[p]),
            .half_evt (half_evt[p])
        );
    end

    host_regs #(.ACC_W(ACC_W), .THR_W(THR_W), .THR_RST(THR_RST)) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr),
        .rd       (host_rd),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .acc      (acc_vec),
        .half_evt (half_evt),
        .rdata    (host_rdata),
        .rvalid   (host_rvalid),
        .irq_n    (irq_n),
        .load     (load),
        .clr      (clr),
        .thr      (thr),
        .hf_flag  (hf_flag),
        .hf_en    (hf_en)
    );
endmodule

// File: rtl/energy_acc_chk.sv
module energy_acc_chk
    import energy_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sample_stb,
    input logic                      host_rd,
    input logic                      host_rvalid,
    input logic                      host_wr,
    input logic [ADDR_W-1:0]         host_addr,
    input logic [REG_W-1:0]          host_wdata,
    input logic [NPH-1:0][ACC_W-1:0] acc_vec,
    input logic [NPH-1:0]            q_up,
    input logic [NPH-1:0]            q_dn,
    input logic [NPH-1:0]            load,
    input logic [NPH-1:0]            clr,
    input logic                      hf_flag,
    input logic                      hf_en,
    input logic                      irq_n
);
    localparam int HB = ACC_W - 2;
    logic [NPH-1:0][ACC_W-1:0] step_v;
    logic [ACC_W-1:0]          wval;

    always_comb begin
        for (int p = 0; p < NPH; p++) step_v[p] = {{(ACC_W-1){q_dn[p]}}, q_up[p] | q_dn[p]};
        wval = host_wdata[ACC_W-1:0];
    end

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        AST_QUANTUM_ADDED: assert property (@(posedge clk) disable iff (!rst_n) (!$past(load[p]) && !$past(clr[p])) |-> acc_vec[p] == $past(acc_vec[p]) + $past(step_v[p])) else $error("quantum step"); // R3
        AST_HALF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (!$past(load[p]) && !$past(clr[p]) && (acc_vec[p][HB] != $past(acc_vec[p][HB]))) |-> hf_flag) else $error("half-full"); // R4
        AST_RDCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ($past(clr[p]) && !$past(load[p])) |-> acc_vec[p] == $past(step_v[p])) else $error("clear on read"); // R7
        AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n) $past(load[p]) |-> acc_vec[p] == $past(wval) + $past(step_v[p])) else $error("load"); // R9
    end

    AST_QUANTUM_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n) (|(q_up | q_dn)) |-> $past(sample_stb)) else $error("quantum w/o strobe"); // R3
    AST_QUANTUM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(q_up & q_dn) == 0) else $error("both directions"); // R3
    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n) (hf_flag && hf_en) |-> !irq_n) else $error("irq low"); // R5
    AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !hf_flag |-> irq_n) else $error("irq high"); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ($past(hf_flag) && !($past(host_wr) && $past(host_addr) == RA_STATUS && $past(host_wdata[HF_BIT]))) |-> hf_flag) else $error("sticky"); // R6
    AST_RVALID_DUE: assert property (@(posedge clk) disable iff (!rst_n) ($past(host_rd) && $past(rst_n)) |-> host_rvalid) else $error("rvalid"); // R8
endmodule

bind energy_acc_bank energy_acc_chk #(.ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_stb  (sample_stb),
    .host_rd     (host_rd),
    .host_rvalid (host_rvalid),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .acc_vec     (acc_vec),
    .q_up        (q_up),
    .q_dn        (q_dn),
    .load        (load),
    .clr         (clr),
    .hf_flag     (hf_flag),
    .hf_en       (hf_en),
    .irq_n       (irq_n)
);

// File: tb/tb_energy_acc_bank.sv
module tb_energy_acc_bank;
    logic clk = 0, rst_n = 0, sample_stb = 0, host_wr = 0, host_rd = 0;
    logic signed [23:0] pwr_a = 0, pwr_b = 0, pwr_c = 0;
    logic [2:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        host_rvalid, irq_n;

    int vectors = 0, fails = 0;
    string cur_req = "R10";

    energy_acc_bank dut (.*);

    always #10 clk = ~clk;

    // behavioural reference model
    logic [31:0] m_acc [3];
    longint      m_integ [3];
    bit          m_up [3], m_dn [3];
    bit          m_flag, m_rvalid;
    logic [7:0]  m_mask, m_mode;
    logic [31:0] m_thr, m_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_acc[p]) begin m_acc[p] = 0; m_integ[p] = 0; m_up[p] = 0; m_dn[p] = 0; end
            m_flag = 0; m_mask = 0; m_mode = 0; m_thr = 1; m_rdata = 0; m_rvalid = 0;
        end else begin
            automatic bit evt = 0;
            automatic longint pw [3] = '{longint'(pwr_a), longint'(pwr_b), longint'(pwr_c)};
            m_rvalid = host_rd;
            if (host_rd) begin
                case (host_addr)
                    0, 1, 2: m_rdata = m_acc[host_addr];
                    3: m_rdata = m_flag ? 32'h10 : 32'h0;
                    4: m_rdata = {24'h0, m_mask};
                    5: m_rdata = {24'h0, m_mode};
                    6: m_rdata = m_thr;
                    default: m_rdata = 0;
                endcase
            end
            for (int p = 0; p < 3; p++) begin
                automatic logic [31:0] base, nxt;
                if (host_wr && host_addr == p) base = host_wdata;
                else if (host_rd && host_addr == p && m_mode[0]) base = 0;
                else base = m_acc[p];
                nxt = base + (m_up[p] ? 32'd1 : 32'd0) - (m_dn[p] ? 32'd1 : 32'd0);
                if (nxt[30] != base[30]) evt = 1;
                m_acc[p] = nxt;
            end
            if (evt) m_flag = 1;
            else if (host_wr && host_addr == 3 && host_wdata[4]) m_flag = 0;
            for (int p = 0; p < 3; p++) begin
                automatic longint s = m_integ[p] + pw[p];
                automatic longint t = longint'(m_thr);
                m_up[p] = 0; m_dn[p] = 0;
                if (sample_stb) begin
                    if (s >= t)       begin m_integ[p] = s - t; m_up[p] = 1; end
                    else if (s <= -t) begin m_integ[p] = s + t; m_dn[p] = 1; end
                    else m_integ[p] = s;
                end
            end
            if (host_wr && host_addr == 4) m_mask = host_wdata[7:0];
            if (host_wr && host_addr == 5) m_mode = host_wdata[7:0];
            if (host_wr && host_addr == 6) m_thr  = host_wdata;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit exp_irq = !(m_flag && m_mask[4]);
            vectors++;
            if (irq_n !== exp_irq) begin
                fails++; $display("FAIL %s irq_n act=%0b exp=%0b", cur_req, irq_n, exp_irq);
            end
            if (host_rvalid !== m_rvalid) begin
                fails++; $display("FAIL R8 rvalid act=%0b exp=%0b", host_rvalid, m_rvalid);
            end
            if (m_rvalid && host_rdata !== m_rdata) begin
                fails++; $display("FAIL %s rdata act=%h exp=%h", cur_req, host_rdata, m_rdata);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++; $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        host_rd = 1; host_addr = a;
        @(negedge clk);
        host_rd = 0;
        d = host_rdata;
    endtask

    task automatic strobe();
        sample_stb = 1;
        @(negedge clk);
        sample_stb = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(5);
        rst_n = 1;
        idle(1);
        // R10 reset state
        chk("R10", {31'h0, irq_n}, 32'h1);
        rd(3, d); chk("R10", d, 32'h0);
        rd(6, d); chk("R10", d, 32'h1);
        rd(0, d); chk("R10", d, 32'h0);
        // R8 register access
        cur_req = "R8";
        wr(4, 32'h10); rd(4, d); chk("R8", d, 32'h10);
        rd(7, d); chk("R8", d, 32'h0);
        wr(4, 32'h0);
        // R3 threshold integration
        cur_req = "R3";
        wr(6, 100);
        pwr_a = 60; pwr_b = -60; pwr_c = 0;
        for (int i = 0; i < 5; i++) begin strobe(); idle(3); end
        rd(0, d); chk("R3", d, 32'd3);
        rd(1, d); chk("R3", d, 32'hFFFFFFFD);
        rd(2, d); chk("R3", d, 32'd0);
        rd(3, d); chk("R4", d, 32'h10);
        // R6 write zero keeps, write one clears
        cur_req = "R6";
        wr(3, 32'h0); rd(3, d); chk("R6", d, 32'h10);
        wr(3, 32'h10); rd(3, d); chk("R6", d, 32'h0);
        pwr_a = 100; pwr_b = 0;
        // R1 positive wrap
        cur_req = "R1";
        wr(0, 32'h7FFFFFFF); idle(1); strobe(); idle(2);
        rd(0, d); chk("R1", d, 32'h80000000);
        // R2 negative wrap
        cur_req = "R2";
        pwr_b = -100;
        wr(1, 32'h80000000); idle(1); strobe(); idle(2);
        pwr_b = 0;
        rd(1, d); chk("R2", d, 32'h7FFFFFFF);
        rd(3, d); chk("R4", d, 32'h10);
        wr(3, 32'h10);
        // R4 / R5 half-full and interrupt
        cur_req = "R5";
        wr(4, 32'h10);
        wr(0, 32'h3FFFFFFF); idle(1); strobe(); idle(2);
        rd(0, d); chk("R4", d, 32'h40000000);
        chk("R5", {31'h0, irq_n}, 32'h0);
        wr(4, 32'h0); idle(1); chk("R5", {31'h0, irq_n}, 32'h1);
        rd(3, d); chk("R4", d, 32'h10);
        wr(4, 32'h10); idle(1); chk("R5", {31'h0, irq_n}, 32'h0);
        wr(3, 32'h10); idle(1); chk("R5", {31'h0, irq_n}, 32'h1);
        // R6 set wins over a same-edge clear
        cur_req = "R6";
        wr(0, 32'h3FFFFFFF); idle(1);
        strobe(); wr(3, 32'h10); idle(1);
        rd(3, d); chk("R6", d, 32'h10);
        chk("R6", {31'h0, irq_n}, 32'h0);
        wr(3, 32'h10);
        // R7 clear-on-read with a coinciding quantum
        cur_req = "R7";
        wr(5, 32'h1); wr(0, 32'd5); idle(1);
        strobe(); rd(0, d); chk("R7", d, 32'd5);
        idle(1);
        rd(0, d); chk("R7", d, 32'd1);
        rd(0, d); chk("R7", d, 32'd0);
        wr(5, 32'h0); strobe(); idle(2);
        rd(0, d); chk("R7", d, 32'd1);
        rd(0, d); chk("R7", d, 32'd1);
        // R9 load with a coinciding quantum
        cur_req = "R9";
        strobe(); wr(0, 32'h100); idle(1);
        rd(0, d); chk("R9", d, 32'h101);
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule